// File: doc/BRIEF.md
# Fractional-Step SPI Serial Clock Generator

This block derives an SPI serial clock from a fast reference clock. Instead of an integer divider, it uses a phase accumulator. Each reference cycle a frequency word is added to the accumulator. Every time the running sum reaches half of a 2048-unit period, the serial clock toggles. The average serial clock rate is therefore the reference rate times the word divided by 2048. A word of 2048 divided by an integer ratio gives exactly that division.

A transfer engine sits next to the block and consumes its outputs. It uses a launch strobe to shift out the next data bit and a latch strobe to sample the incoming bit. Each strobe is one reference cycle long and coincides with the serial clock edge selected for it. The clock's idle level is programmable. A rate doubler and an option that discards the accumulator remainder on every wrap are also available; the second option trades average accuracy for uniform periods. A registered flag tells the capture logic when the configured rate is too fast for a synchronous input path.

Top module: `spi_clk_gen`

## Requirements
- R1: While `en_i` is low, the accumulator holds zero, `sclk_o` equals `cpol_i` one cycle later, and both strobes stay low.
- R2: While enabled, each reference cycle adds the effective step to the accumulator. When the sum reaches 1024, `sclk_o` toggles on that edge and the accumulator keeps the sum minus 1024.
- R3: With `rst_on_loop_i` high, the accumulator is cleared to zero on every toggle instead of keeping the remainder.
- R4: With `dbl_rate_i` high, the effective step is twice `freq_ctrl_i`.
- R5: The effective step saturates at 1024, so `sclk_o` toggles at most once per reference cycle. With a step at or above 1024, it toggles on every enabled cycle.
- R6: The first toggle after enabling moves `sclk_o` away from the `cpol_i` idle level. A step of zero produces no toggle.
- R7: `launch_o` pulses for exactly one cycle, in the same cycle that `sclk_o` shows a new level equal to `launch_rise_i` (1 = rising edge, 0 = falling edge).
- R8: `latch_o` pulses for exactly one cycle, in the same cycle that `sclk_o` shows a new level equal to `latch_rise_i` (1 = rising edge, 0 = falling edge).
- R9: `async_in_o` is registered and is high when the effective step times `REF_HZ` exceeds `SYNC_MAX_HZ` times 2048. With the defaults (200 MHz and 30 MHz), this means an effective step of 308 or more. The flag does not depend on `en_i`.
- R10: During reset, `sclk_o`, `launch_o`, `latch_o` and `async_in_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the serial clock |
| freq_ctrl_i | input | 16 | Frequency word, in 1/2048 of the reference rate |
| rst_on_loop_i | input | 1 | Discard accumulator remainder on each toggle |
| dbl_rate_i | input | 1 | Double the effective step |
| cpol_i | input | 1 | Idle level of the serial clock |
| launch_rise_i | input | 1 | Launch on rising (1) or falling (0) edge |
| latch_rise_i | input | 1 | Latch on rising (1) or falling (0) edge |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle data launch strobe |
| latch_o | output | 1 | One-cycle data sample strobe |
| async_in_o | output | 1 | Select the asynchronous input capture path |

## Verification
Every output is a register. Each result therefore appears exactly one reference cycle after the rising edge that sampled the inputs: the toggle, the strobes, the idle level and the rate flag. The bench changes inputs on the falling edge. It then compares against a cycle model on the following falling edge, so each comparison covers exactly one accumulator step. The model is driven from the requirement arithmetic: a remainder either kept or cleared, a step doubled and then saturated, and edge direction taken from the new level. Long runs of non-integer ratios expose the uneven periods that a kept remainder produces.

// File: rtl/spi_clk_gen_pkg.sv
package spi_clk_gen_pkg;
  typedef struct packed {
    logic latch_rise;
    logic launch_rise;
  } edge_cfg_t;
endpackage

// File: rtl/sclk_step_sel.sv
module sclk_step_sel #(
  parameter int FCW_W     = 16,
  parameter int HALF_LOG2 = 10,
  localparam int STEP_W   = HALF_LOG2 + 1
) (
  input  logic [FCW_W-1:0]  freq_ctrl_i,
  input  logic              dbl_rate_i,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [FCW_W:0] HALF = (FCW_W+1)'(1) << HALF_LOG2;

  logic [FCW_W:0] raw;

  always_comb begin
    raw = dbl_rate_i ? {freq_ctrl_i, 1'b0} : {1'b0, freq_ctrl_i};
    // at most one edge per reference cycle
    if (raw > HALF) raw = HALF;
    step_o = raw[STEP_W-1:0];
  end
endmodule

// File: rtl/sclk_phase_acc.sv
module sclk_phase_acc #(
  parameter int HALF_LOG2 = 10,
  localparam int STEP_W   = HALF_LOG2 + 1,
  localparam int ACC_W    = HALF_LOG2 + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rst_on_loop_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              wrap_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << HALF_LOG2;

  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum    = acc_q + ACC_W'(step_i);
    wrap_o = en_i && (sum >= HALF);
    if (!en_i)      acc_d = '0;
    else if (wrap_o) acc_d = rst_on_loop_i ? '0 : sum - HALF;
    else            acc_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen
  import spi_clk_gen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      cpol_i,
  input  logic      wrap_i,
  input  edge_cfg_t cfg_i,
  output logic      sclk_o,
  output logic      launch_o,
  output logic      latch_o
);
  logic       sclk_q, sclk_d;
  logic [1:0] stb_q, stb_d, sel;

  assign sel = {cfg_i.latch_rise, cfg_i.launch_rise};

  always_comb begin
    sclk_d = sclk_q;
    if (!en_i)       sclk_d = cpol_i;
    else if (wrap_i) sclk_d = ~sclk_q;
  end

  for (genvar g = 0; g < 2; g++) begin : g_stb
    assign stb_d[g] = en_i && wrap_i && (sclk_d == sel[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      stb_q  <= '0;
    end else begin
      sclk_q <= sclk_d;
      stb_q  <= stb_d;
    end
  end

  assign sclk_o   = sclk_q;
  assign launch_o = stb_q[0];
  assign latch_o  = stb_q[1];
endmodule

// File: rtl/sclk_rate_flag.sv
module sclk_rate_flag #(
  parameter int REF_HZ      = 200_000_000,
  parameter int SYNC_MAX_HZ = 30_000_000,
  parameter int HALF_LOG2   = 10,
  localparam int STEP_W     = HALF_LOG2 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  output logic              async_o
);
  localparam logic [63:0] LIMIT = 64'(SYNC_MAX_HZ) << (HALF_LOG2 + 1);

  logic [63:0] prod;
  assign prod = 64'(step_i) * 64'(REF_HZ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) async_o <= 1'b0;
    else         async_o <= (prod > LIMIT);
  end
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_clk_gen_pkg::*;
#(
  parameter int FCW_W       = 16,
  parameter int HALF_LOG2   = 10,
  parameter int REF_HZ      = 200_000_000,
  parameter int SYNC_MAX_HZ = 30_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [FCW_W-1:0] freq_ctrl_i,
  input  logic             rst_on_loop_i,
  input  logic             dbl_rate_i,
  input  logic             cpol_i,
  input  logic             launch_rise_i,
  input  logic             latch_rise_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             latch_o,
  output logic             async_in_o
);
  localparam int STEP_W = HALF_LOG2 + 1;

  logic [STEP_W-1:0] step;
  logic              wrap;
  edge_cfg_t         cfg;

  assign cfg = '{latch_rise: latch_rise_i, launch_rise: launch_rise_i};

  sclk_step_sel #(.FCW_W(FCW_W), .HALF_LOG2(HALF_LOG2)) u_step (
    .freq_ctrl_i(freq_ctrl_i), .dbl_rate_i(dbl_rate_i), .step_o(step)
  );

  sclk_phase_acc #(.HALF_LOG2(HALF_LOG2)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .rst_on_loop_i(rst_on_loop_i), .step_i(step), .wrap_o(wrap)
  );

  sclk_edge_gen u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cpol_i(cpol_i),
    .wrap_i(wrap), .cfg_i(cfg),
    .sclk_o(sclk_o), .launch_o(launch_o), .latch_o(latch_o)
  );

  sclk_rate_flag #(
    .REF_HZ(REF_HZ), .SYNC_MAX_HZ(SYNC_MAX_HZ), .HALF_LOG2(HALF_LOG2)
  ) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .async_o(async_in_o)
  );
endmodule

// File: rtl/spi_clk_gen_chk.sv
module spi_clk_gen_chk #(
  parameter int FCW_W     = 16,
  parameter int HALF_LOG2 = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [FCW_W-1:0] freq_ctrl_i,
  input logic             dbl_rate_i,
  input logic             cpol_i,
  input logic             launch_rise_i,
  input logic             latch_rise_i,
  input logic             sclk_o,
  input logic             launch_o,
  input logic             latch_o,
  input logic             async_in_o
);
  localparam logic [FCW_W-1:0] HALF     = FCW_W'(1) << HALF_LOG2;
  localparam logic [FCW_W-1:0] HALF_DBL = FCW_W'(1) << (HALF_LOG2 - 1);

  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)) && !launch_o && !latch_o);

  p_full_rate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (freq_ctrl_i >= (dbl_rate_i ? HALF_DBL : HALF)) |=> sclk_o != $past(sclk_o));

  p_zero_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (freq_ctrl_i == '0) |=> $stable(sclk_o));

  p_launch_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> (sclk_o != $past(sclk_o)) && (sclk_o == $past(launch_rise_i)));

  p_latch_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |-> (sclk_o != $past(sclk_o)) && (sclk_o == $past(latch_rise_i)));

  p_slow_sync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_ctrl_i == '0) |=> !async_in_o);
endmodule

bind spi_clk_gen spi_clk_gen_chk #(.FCW_W(FCW_W), .HALF_LOG2(HALF_LOG2)) u_chk (.*);

// File: tb/spi_clk_gen_tb_top.sv
`timescale 1ns/1ps
module spi_clk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] fcw = '0;
  logic        rol = 1'b0, dbl = 1'b0, cpol = 1'b0, lr = 1'b0, tr = 1'b0;
  logic        sclk, launch, latch, async_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_acc;
  bit m_sclk;

  always #2.5 clk = ~clk;

  spi_clk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .freq_ctrl_i(fcw),
    .rst_on_loop_i(rol), .dbl_rate_i(dbl), .cpol_i(cpol),
    .launch_rise_i(lr), .latch_rise_i(tr),
    .sclk_o(sclk), .launch_o(launch), .latch_o(latch), .async_in_o(async_in)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R10: reset state
  task automatic t_reset();
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 sclk", sclk, 0);
    chk("R10 launch", launch, 0);
    chk("R10 latch", latch, 0);
    chk("R10 async", async_in, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1 idle, then R2..R8 against a cycle model built from the requirements
  task automatic run_cfg(string tag, int f, bit r, bit d, bit p, bit l, bit t, int n);
    int step, sum;
    bit tog;
    en = 1'b0; fcw = 16'(f); rol = r; dbl = d; cpol = p; lr = l; tr = t;
    repeat (2) begin
      tick();
      chk("R1 idle sclk", sclk, p);
      chk("R1 idle strobes", {launch, latch}, 0);
    end
    m_acc = 0; m_sclk = p;
    en = 1'b1;
    for (int i = 0; i < n; i++) begin
      step = d ? 2 * f : f;
      if (step > 1024) step = 1024;
      sum = m_acc + step;
      tog = (sum >= 1024);
      if (tog) begin
        m_acc = r ? 0 : sum - 1024;
        m_sclk = ~m_sclk;
      end else m_acc = sum;
      tick();
      chk({tag, " sclk"}, sclk, m_sclk);
      chk("R7 launch", launch, tog && (m_sclk == l));
      chk("R8 latch", latch, tog && (m_sclk == t));
    end
    en = 1'b0;
  endtask

  // R9: rate flag, one cycle after inputs
  task automatic t_flag(int f, bit d);
    longint step;
    fcw = 16'(f); dbl = d;
    tick();
    step = d ? 2 * f : f;
    if (step > 1024) step = 1024;
    chk("R9 async", async_in, (step * 200_000_000) > (longint'(30_000_000) * 2048));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    run_cfg("R2 half", 512, 0, 0, 0, 1, 0, 20);
    run_cfg("R2 frac", 700, 0, 0, 0, 0, 1, 60);
    run_cfg("R3 rol", 700, 1, 0, 0, 1, 1, 60);
    run_cfg("R3 rol slow", 300, 1, 0, 1, 0, 0, 60);
    run_cfg("R4 dbl", 300, 0, 1, 0, 1, 0, 60);
    run_cfg("R4 dbl rol", 333, 1, 1, 1, 0, 1, 60);
    run_cfg("R5 clamp", 5000, 0, 0, 0, 1, 0, 12);
    run_cfg("R5 clamp dbl", 600, 0, 1, 1, 0, 1, 12);
    run_cfg("R6 cpol1", 2048 / 6, 0, 0, 1, 1, 0, 40);
    run_cfg("R6 zero", 0, 0, 0, 1, 1, 1, 10);
    run_cfg("R7 prime", 97, 0, 0, 0, 0, 0, 120);
    t_flag(307, 0);
    t_flag(308, 0);
    t_flag(153, 1);
    t_flag(154, 1);
    t_flag(40000, 0);
    t_flag(0, 0);
    done = 1;
    summary();
    $finish;
  end
endmodule